// File: doc/BRIEF.md
# Micro-op Group Sequencer

This block sits behind an instruction decoder and turns each decoded macro-instruction into one or more wide micro-op groups. A group has four slots and one 32-bit immediate that all of its slots share. Short translations come straight out of a combinational decode stage as one complete group.

An instruction that needs two different large literals is split into two direct groups, and each group carries its own literal. Longer translations use a small constant microcode ROM. The decode stage emits the first group and the ROM start address in the same cycle. The ROM groups then follow back to back, each ROM entry naming the next address and whether it ends the sequence.

Every slot also reports how many issue cycles it takes. This count comes from a fixed table indexed by the micro-opcode. Memory-operand micro-ops, including read-modify-write forms, take more than one issue cycle.

Top module: `uop_sequencer`

## Requirements
- R1: Classes 0 to 3 produce exactly one group with `out_last`=1. Slot 0 is encoded as follows: class 0 is {op 1, rd, rs1, rs2, imm-use 0}; class 1 is {op 2, rd, rs1, 0, 1}; class 2 is {op 8, rd, rs1, rs2, 1}; class 3 is {op 12, 0, rs1, rs2, 1}. The group carries `in_imm_a`.
- R2: Class 4 produces two groups. The first has slot 0 {op 3, rd 15, 0, 0, imm-use 1} and carries `in_imm_a`. The second has slot 0 op 13 and carries `in_imm_b`.
- R3: Classes 5, 6 and 7 emit a direct first group, followed by ROM groups on consecutive cycles with no cycle of `out_valid`=0 between them. The slot-0 opcodes in order are: class 5 gives 9,13,4,20; class 6 gives 3,12; class 7 gives 1,9,13. Every group carries `in_imm_a`. The direct first group of class 5 has slot 0 {op 9, rd 14, rs1, 0, 1}, and that of class 6 has slot 0 {op 3, rd 5, 0, 0, 1}.
- R4: `out_last` is 1 only on the final group of an instruction. `in_ready` is 1 again in the cycle after that group is taken.
- R5: At most one valid slot in any group has its imm-use bit set.
- R6: `out_issue[2i+1:2i]` gives the issue count of slot i: 0 if the slot is invalid, 3 for op 12, 2 for ops 8, 9 and 13, and 1 for any other valid op.
- R7: While `out_ready`=0 during a split or ROM sequence, the group, the immediate and the sequence position stay unchanged. No new instruction is taken until the sequence ends.
- R8: A synchronous reset deasserts `out_valid` and `in_ready` and abandons any sequence. The block then returns to direct decode.
- R9: The slot layout is fixed: slot i sits at `out_slots[20i+19:20i]`, with valid at bit 19, op at bits 18:13, rd at 12:9, rs1 at 8:5, rs2 at 4:1 and imm-use at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction taken this cycle when both are high |
| in_cls | input | 3 | Opcode class |
| in_rd | input | 4 | Destination register |
| in_rs1 | input | 4 | First source register |
| in_rs2 | input | 4 | Second source register |
| in_imm_a | input | 32 | Primary literal |
| in_imm_b | input | 32 | Second literal (class 4) |
| out_valid | output | 1 | Group present |
| out_ready | input | 1 | Consumer takes group |
| out_slots | output | 80 | Four packed slots |
| out_imm | output | 32 | Shared immediate of the group |
| out_last | output | 1 | Final group of the instruction |
| out_issue | output | 8 | Per-slot issue counts |

## Verification
The direct first group depends only on the inputs in the idle state. It is therefore checked 1 ns after the inputs change at the falling edge, in the same cycle. Each split or ROM group appears one rising edge after the previous group is taken, so the bench samples once per falling edge and expects a new group every cycle. In the stall test, a frozen group is sampled over several falling edges with `out_ready` low. Recovery after reset is checked in the first cycle after the reset edge.

// File: rtl/uop_pkg.sv
package uop_pkg;
  parameter int SLOTS  = 4;
  parameter int OPW    = 6;
  parameter int REGW   = 4;
  parameter int IMMW   = 32;
  parameter int CLSW   = 3;
  parameter int ROM_AW = 3;
  parameter int ISSW   = 2;

  typedef struct packed {
    logic            v;
    logic [OPW-1:0]  op;
    logic [REGW-1:0] rd;
    logic [REGW-1:0] rs1;
    logic [REGW-1:0] rs2;
    logic            use_imm;
  } slot_t;

  localparam int SLOTW = $bits(slot_t);

  typedef slot_t [SLOTS-1:0] grp_t;

  typedef struct packed {
    grp_t              grp;
    logic              last;
    logic [ROM_AW-1:0] nxt;
  } rom_ent_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SPLIT, ST_ROM} seq_state_t;

  localparam logic [OPW-1:0] OP_ADD  = 6'd1;
  localparam logic [OPW-1:0] OP_ADDI = 6'd2;
  localparam logic [OPW-1:0] OP_MOVI = 6'd3;
  localparam logic [OPW-1:0] OP_INC  = 6'd4;
  localparam logic [OPW-1:0] OP_LDOP = 6'd8;
  localparam logic [OPW-1:0] OP_LD   = 6'd9;
  localparam logic [OPW-1:0] OP_RMW  = 6'd12;
  localparam logic [OPW-1:0] OP_ST   = 6'd13;
  localparam logic [OPW-1:0] OP_BRNZ = 6'd20;

  function automatic slot_t mk_slot(logic [OPW-1:0] op, logic [REGW-1:0] rd,
                                    logic [REGW-1:0] rs1, logic [REGW-1:0] rs2,
                                    logic u);
    slot_t s;
    s.v = 1'b1; s.op = op; s.rd = rd; s.rs1 = rs1; s.rs2 = rs2; s.use_imm = u;
    return s;
  endfunction

  // Static issue-count table: memory forms are multi-issue.
  function automatic logic [ISSW-1:0] issue_of(slot_t s);
    if (!s.v)                                          return 2'd0;
    if (s.op == OP_RMW)                                return 2'd3;
    if (s.op == OP_LDOP || s.op == OP_LD || s.op == OP_ST) return 2'd2;
    return 2'd1;
  endfunction
endpackage

// File: rtl/uop_decode.sv
module uop_decode
  import uop_pkg::*;
(
  input  logic [CLSW-1:0]   cls,
  input  logic [REGW-1:0]   rd,
  input  logic [REGW-1:0]   rs1,
  input  logic [REGW-1:0]   rs2,
  output grp_t              first_grp,
  output grp_t              split_grp,
  output logic              need_split,
  output logic              rom_go,
  output logic [ROM_AW-1:0] rom_idx
);
  localparam logic [REGW-1:0] R_TMP = '1;
  localparam logic [REGW-1:0] R_BUF = 4'd14;
  localparam logic [REGW-1:0] R_CNT = 4'd5;

  always_comb begin
    first_grp  = '0;
    split_grp  = '0;
    need_split = 1'b0;
    rom_go     = 1'b0;
    rom_idx    = '0;
    case (cls)
      3'd0: first_grp[0] = mk_slot(OP_ADD,  rd, rs1, rs2, 1'b0);
      3'd1: first_grp[0] = mk_slot(OP_ADDI, rd, rs1, '0,  1'b1);
      3'd2: first_grp[0] = mk_slot(OP_LDOP, rd, rs1, rs2, 1'b1);
      3'd3: first_grp[0] = mk_slot(OP_RMW,  '0, rs1, rs2, 1'b1);
      3'd4: begin
        // two literals: one group each
        first_grp[0] = mk_slot(OP_MOVI, R_TMP, '0, '0, 1'b1);
        split_grp[0] = mk_slot(OP_ST, '0, '0, R_TMP, 1'b1);
        need_split   = 1'b1;
      end
      3'd5: begin
        first_grp[0] = mk_slot(OP_LD, R_BUF, rs1, '0, 1'b1);
        rom_go = 1'b1; rom_idx = 3'd0;
      end
      3'd6: begin
        first_grp[0] = mk_slot(OP_MOVI, R_CNT, '0, '0, 1'b1);
        rom_go = 1'b1; rom_idx = 3'd3;
      end
      default: begin
        first_grp[0] = mk_slot(OP_ADD, rd, rs1, rs2, 1'b0);
        rom_go = 1'b1; rom_idx = 3'd4;
      end
    endcase
  end
endmodule

// File: rtl/uop_rom.sv
module uop_rom
  import uop_pkg::*;
(
  input  logic [ROM_AW-1:0] addr,
  output rom_ent_t          ent
);
  function automatic rom_ent_t rom_word(logic [ROM_AW-1:0] a);
    rom_ent_t e;
    e = '0;
    e.last = 1'b1;
    case (a)
      3'd0: begin
        e.grp[0] = mk_slot(OP_ST,  '0,   4'd1, 4'd14, 1'b1);
        e.grp[1] = mk_slot(OP_INC, 4'd1, 4'd1, '0,    1'b0);
        e.last = 1'b0; e.nxt = 3'd1;
      end
      3'd1: begin
        e.grp[0] = mk_slot(OP_INC, 4'd2, 4'd2, '0, 1'b0);
        e.last = 1'b0; e.nxt = 3'd2;
      end
      3'd2: e.grp[0] = mk_slot(OP_BRNZ, '0, 4'd3, '0, 1'b1);
      3'd3: begin
        e.grp[0] = mk_slot(OP_RMW, '0,   4'd5, 4'd6, 1'b1);
        e.grp[1] = mk_slot(OP_ADD, 4'd7, 4'd7, 4'd6, 1'b0);
      end
      3'd4: begin
        e.grp[0] = mk_slot(OP_LD, 4'd8, 4'd9, '0, 1'b1);
        e.last = 1'b0; e.nxt = 3'd6;
      end
      3'd6: e.grp[0] = mk_slot(OP_ST, '0, 4'd10, 4'd8, 1'b1);
      default: e.grp = '0;
    endcase
    return e;
  endfunction

  assign ent = rom_word(addr);
endmodule

// File: rtl/uop_issue_tbl.sv
module uop_issue_tbl
  import uop_pkg::*;
(
  input  grp_t                    grp,
  output logic [SLOTS*ISSW-1:0]   cnt
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign cnt[i*ISSW +: ISSW] = issue_of(grp[i]);
  end
endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer
  import uop_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CLSW-1:0]         in_cls,
  input  logic [REGW-1:0]         in_rd,
  input  logic [REGW-1:0]         in_rs1,
  input  logic [REGW-1:0]         in_rs2,
  input  logic [IMMW-1:0]         in_imm_a,
  input  logic [IMMW-1:0]         in_imm_b,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [SLOTS*SLOTW-1:0]  out_slots,
  output logic [IMMW-1:0]         out_imm,
  output logic                    out_last,
  output logic [SLOTS*ISSW-1:0]   out_issue
);
  seq_state_t        state;
  logic [ROM_AW-1:0] rom_addr;
  logic [IMMW-1:0]   imm_hold;
  grp_t              split_q;

  grp_t              dec_first, dec_split, cur_grp;
  logic              dec_split_need, dec_rom_go;
  logic [ROM_AW-1:0] dec_rom_idx;
  rom_ent_t          rom_ent;

  uop_decode i_dec (
    .cls(in_cls), .rd(in_rd), .rs1(in_rs1), .rs2(in_rs2),
    .first_grp(dec_first), .split_grp(dec_split),
    .need_split(dec_split_need), .rom_go(dec_rom_go), .rom_idx(dec_rom_idx)
  );

  uop_rom i_rom (.addr(rom_addr), .ent(rom_ent));

  uop_issue_tbl i_iss (.grp(cur_grp), .cnt(out_issue));

  // named events for checks
  logic take_in, take_out, rom_start;
  logic [SLOTS-1:0] imm_use_vec;

  always_comb begin
    out_valid = 1'b0;
    in_ready  = 1'b0;
    cur_grp   = dec_first;
    out_imm   = in_imm_a;
    out_last  = 1'b1;
    case (state)
      ST_IDLE: begin
        out_valid = in_valid & ~rst;
        in_ready  = out_ready & ~rst;
        out_last  = ~(dec_split_need | dec_rom_go);
      end
      ST_SPLIT: begin
        out_valid = ~rst;
        cur_grp   = split_q;
        out_imm   = imm_hold;
      end
      default: begin
        out_valid = ~rst;
        cur_grp   = rom_ent.grp;
        out_imm   = imm_hold;
        out_last  = rom_ent.last;
      end
    endcase
  end

  assign out_slots = cur_grp;
  assign take_in   = in_valid & in_ready;
  assign take_out  = out_valid & out_ready;
  assign rom_start = take_in & dec_rom_go & ~dec_split_need;

  for (genvar i = 0; i < SLOTS; i++) begin : g_use
    assign imm_use_vec[i] = cur_grp[i].v & cur_grp[i].use_imm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rom_addr <= '0;
      imm_hold <= '0;
      split_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (take_in) begin
          if (dec_split_need) begin
            state    <= ST_SPLIT;
            split_q  <= dec_split;
            imm_hold <= in_imm_b;
          end else if (dec_rom_go) begin
            state    <= ST_ROM;
            rom_addr <= dec_rom_idx;
            imm_hold <= in_imm_a;
          end
        end
        ST_SPLIT: if (out_ready) state <= ST_IDLE;
        default: if (out_ready) begin
          if (rom_ent.last) state <= ST_IDLE;
          else              rom_addr <= rom_ent.nxt;
        end
      endcase
    end
  end

  AST_ONE_IMM_USER: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(imm_use_vec) <= 1); // R5
  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !in_ready); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && !out_ready) |=>
      ($stable(out_slots) && $stable(out_imm) && $stable(rom_addr))); // R7
  AST_ROM_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    rom_start |=> (state == ST_ROM && out_valid)); // R3
  AST_LAST_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (take_out && out_last) |=> state == ST_IDLE); // R4
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE)); // R8
endmodule

// File: tb/test_uop_sequencer.sv
module test_uop_sequencer;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_last;
  logic [2:0]  in_cls = '0;
  logic [3:0]  in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [31:0] in_imm_a = '0, in_imm_b = '0, out_imm;
  logic [79:0] out_slots;
  logic [7:0]  out_issue;
  int checks = 0, errs = 0;

  always #2.5 clk = ~clk;

  uop_sequencer i_uop_sequencer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_imm_a(in_imm_a), .in_imm_b(in_imm_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_slots(out_slots), .out_imm(out_imm),
    .out_last(out_last), .out_issue(out_issue)
  );

  typedef struct packed {
    logic [2:0] cls; logic [3:0] rd, rs1, rs2;
    logic [31:0] ia, ib; logic [2:0] ngrp; logic [23:0] ops;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 4'd3, 4'd4, 4'd5, 32'h0000_1111, 32'h0, 3'd1, {18'd0, 6'd1}},
    '{3'd0, 4'd9, 4'd0, 4'd15, 32'hFFFF_FFFF, 32'h0, 3'd1, {18'd0, 6'd1}},
    '{3'd1, 4'd2, 4'd7, 4'd1, 32'h8000_0001, 32'h0, 3'd1, {18'd0, 6'd2}},
    '{3'd2, 4'd6, 4'd8, 4'd9, 32'h0000_0040, 32'h0, 3'd1, {18'd0, 6'd8}},
    '{3'd3, 4'd1, 4'd11, 4'd12, 32'h0000_0100, 32'h0, 3'd1, {18'd0, 6'd12}},
    '{3'd4, 4'd0, 4'd0, 4'd0, 32'hDEAD_BEEF, 32'hCAFE_0000, 3'd2, {12'd0, 6'd13, 6'd3}},
    '{3'd4, 4'd0, 4'd0, 4'd0, 32'h1, 32'h2, 3'd2, {12'd0, 6'd13, 6'd3}},
    '{3'd5, 4'd0, 4'd13, 4'd0, 32'h0000_2000, 32'h0, 3'd4, {6'd20, 6'd4, 6'd13, 6'd9}},
    '{3'd6, 4'd0, 4'd0, 4'd0, 32'h0000_0007, 32'h0, 3'd2, {12'd0, 6'd12, 6'd3}},
    '{3'd7, 4'd4, 4'd5, 4'd6, 32'h1234_5678, 32'h0, 3'd3, {6'd0, 6'd13, 6'd9, 6'd1}}
  };

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] enc(input logic [5:0] op, input logic [3:0] rd,
                                      input logic [3:0] a, input logic [3:0] b, input logic u);
    return {1'b1, op, rd, a, b, u};
  endfunction

  function automatic logic [19:0] exp_first(input vec_t v);
    case (v.cls)
      3'd0: return enc(6'd1, v.rd, v.rs1, v.rs2, 1'b0);
      3'd1: return enc(6'd2, v.rd, v.rs1, 4'd0, 1'b1);
      3'd2: return enc(6'd8, v.rd, v.rs1, v.rs2, 1'b1);
      3'd3: return enc(6'd12, 4'd0, v.rs1, v.rs2, 1'b1);
      3'd4: return enc(6'd3, 4'd15, 4'd0, 4'd0, 1'b1);
      3'd5: return enc(6'd9, 4'd14, v.rs1, 4'd0, 1'b1);
      3'd6: return enc(6'd3, 4'd5, 4'd0, 4'd0, 1'b1);
      default: return enc(6'd1, v.rd, v.rs1, v.rs2, 1'b0);
    endcase
  endfunction

  // R5 and R6 on whatever group is currently shown
  task automatic check_group_rules();
    int users = 0;
    for (int s = 0; s < 4; s++) begin
      logic [19:0] sl = out_slots[20*s +: 20];
      logic [1:0] e;
      if (sl[19] && sl[0]) users++;
      if (!sl[19]) e = 2'd0;
      else if (sl[18:13] == 6'd12) e = 2'd3;
      else if (sl[18:13] == 6'd8 || sl[18:13] == 6'd9 || sl[18:13] == 6'd13) e = 2'd2;
      else e = 2'd1;
      chk(out_issue[2*s +: 2] == e, "R6 issue", 80'(out_issue[2*s +: 2]), 80'(e));
    end
    chk(users <= 1, "R5 imm users", 80'(users), 80'd1);
  endtask

  task automatic drive(input vec_t v);
    in_cls = v.cls; in_rd = v.rd; in_rs1 = v.rs1; in_rs2 = v.rs2;
    in_imm_a = v.ia; in_imm_b = v.ib; in_valid = 1'b1;
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    drive(v); out_ready = 1'b1;
    #1;
    chk(out_slots[19:0] == exp_first(v), "R1/R9 first slot", 80'(out_slots[19:0]), 80'(exp_first(v)));
    for (int g = 0; g < int'(v.ngrp); g++) begin
      logic [31:0] ei = (v.cls == 3'd4 && g == 1) ? v.ib : v.ia;
      if (g > 0) begin @(negedge clk); in_valid = 1'b0; #1; end
      chk(out_valid == 1'b1, "R3 no bubble", 80'(out_valid), 80'd1);
      chk(out_slots[18:13] == v.ops[6*g +: 6], "R3 slot0 op", 80'(out_slots[18:13]), 80'(v.ops[6*g +: 6]));
      chk(out_imm == ei, "R2 imm", 80'(out_imm), 80'(ei));
      chk(out_last == (g == int'(v.ngrp) - 1), "R4 last", 80'(out_last), 80'(g == int'(v.ngrp) - 1));
      chk(in_ready == (g == 0), "R7 ready", 80'(in_ready), 80'(g == 0));
      check_group_rules();
    end
    @(negedge clk); in_valid = 1'b0; #1;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R4 back to idle", 80'({in_ready, out_valid}), 80'b10);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [79:0] held;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R8 reset state", 80'({out_valid, in_ready}), 80'd0);
    in_valid = 1'b1; out_ready = 1'b1; #1;
    chk(out_valid == 1'b0, "R8 valid masked in reset", 80'(out_valid), 80'd0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R7: stall in middle of the class-5 ROM sequence
    @(negedge clk); drive(VECS[7]); out_ready = 1'b1;
    @(negedge clk); drive(VECS[0]); out_ready = 1'b0; #1;
    held = out_slots;
    chk(in_ready == 1'b0, "R7 busy no take", 80'(in_ready), 80'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(out_valid && out_slots == held && out_imm == VECS[7].ia, "R7 hold", out_slots, held);
    end
    out_ready = 1'b1; #1;
    chk(out_slots[18:13] == 6'd13, "R7 resume rom0", 80'(out_slots[18:13]), 80'd13);
    @(negedge clk); #1;
    chk(out_slots[18:13] == 6'd4, "R7 rom1", 80'(out_slots[18:13]), 80'd4);
    @(negedge clk); #1;
    chk(out_slots[18:13] == 6'd20 && out_last, "R7 rom2", 80'(out_slots[18:13]), 80'd20);
    @(negedge clk); #1;
    chk(in_ready && out_slots[19:0] == exp_first(VECS[0]), "R7 next taken after",
        80'(out_slots[19:0]), 80'(exp_first(VECS[0])));
    @(negedge clk); in_valid = 1'b0;

    // R8: reset abandons a sequence
    @(negedge clk); drive(VECS[9]); out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0; rst = 1'b1; #1;
    chk(out_valid == 1'b0, "R8 reset mid-seq", 80'(out_valid), 80'd0);
    @(negedge clk); rst = 1'b0; drive(VECS[2]); #1;
    chk(out_valid && out_last && out_slots[19:0] == exp_first(VECS[2]), "R8 direct after reset",
        80'(out_slots[19:0]), 80'(exp_first(VECS[2])));
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule